// File: doc/BRIEF.md
# Bridge Master-Abort Response Handler

This block sits beside a bridge that forwards transactions between a hub-side link and a PCI bus. When a transaction that crossed the bridge ends in a master abort, the bridge has to choose how to finish it. The handler takes an abort event strobe and the class of the transaction that aborted, and returns a set of registered response flags for that single event. The flags are a completion status, a flag that replaces read data with all ones, a discard indication, a request to pass through the data carried in the hub's abort packet, a prefetch-flush request, a target-abort request and a system-error request.

A configuration bit selects the policy. With the bit clear, aborts finish quietly. With the bit set, aborts are treated as errors: they are converted to target aborts, prefetched data is flushed, and a system-error request is raised when it is enabled. The handler keeps a sticky record of system-error requests, and software clears that record with a write-one-to-clear strobe. Bus protocols and data buffers are handled elsewhere. This block only decides the response.

Top module: `mabort_handler`

## Requirements
- R1: After reset the policy bit and the system-error enable are 0, every response output is 0, and `serr_sticky` is 0. Until a configuration write, an abort behaves as in policy 0.
- R2: Class 0 (completion-required request from the hub side) with policy 0: one cycle after the strobe, `resp_valid`=1, `resp_status`=2'b01 (master abort) and `force_ones`=1. All other flags are 0.
- R3: Class 0 with policy 1: one cycle after the strobe, `resp_valid`=1, `resp_status`=2'b10 (target abort) and `force_ones`=1. All other flags are 0.
- R4: Class 1 (posted write from the hub side): in both policies, `resp_valid`=1, `discard`=1 and `resp_status`=2'b00, with no data forcing.
- R5: `serr_req` is raised only for class 1 with policy 1 and the enable set. In that case `serr_sticky` is set on the same edge. In every other case `serr_req` stays 0.
- R6: Class 2 (PCI read to the hub side) with policy 0: `resp_valid`=1 and `relay_pkt_data`=1, with status 2'b00 and no flush or target-abort request.
- R7: Class 2 with policy 1: `resp_valid`=1, `tgt_abort_req`=1, `flush_prefetch`=1 and `resp_status`=2'b10.
- R8: Class 3 (PCI write to the hub side) produces no response. Every output flag stays 0, including `resp_valid`.
- R9: Response outputs last exactly one cycle. In a cycle that follows no strobe, every response output is 0.
- R10: `serr_sticky` holds until a cycle with `serr_clr`=1 and no new set. When a set and a clear fall in the same cycle, the set wins.
- R11: A configuration write (`cfg_we`) loads the policy and the enable at the clock edge. A strobe in the same cycle as the write still uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the policy and enable bits |
| cfg_abort_is_err | input | 1 | Policy bit to load (1 = treat abort as error) |
| cfg_serr_en | input | 1 | System-error enable to load |
| serr_clr | input | 1 | Write-one-to-clear strobe for the sticky bit |
| abort_stb | input | 1 | A master abort occurred this cycle |
| txn_class | input | 2 | Class of the aborted transaction (0..3) |
| resp_valid | output | 1 | A response is being issued |
| resp_status | output | 2 | 00 normal, 01 master abort, 10 target abort |
| force_ones | output | 1 | Replace read data with all ones |
| discard | output | 1 | Drop the write data |
| relay_pkt_data | output | 1 | Return the abort packet's data to the requester |
| flush_prefetch | output | 1 | Flush the rest of the prefetched data |
| tgt_abort_req | output | 1 | End the PCI cycle with a target abort |
| serr_req | output | 1 | System-error request pulse |
| serr_sticky | output | 1 | Sticky record of system-error requests |

## Verification
The bench covers every class under both policies. It targets the posted-write case with the enable both set and clear: a design that ignored the enable, or that ignored the policy, would raise `serr_req` wrongly. It drives a set and a clear of the sticky bit in the same cycle, which catches a design where the clear wins. It also issues a strobe in the same cycle as a configuration write, which exposes a design that applies the new policy one cycle early. Finally, it checks the cycle after each strobe for leftover flags, and it checks that a mid-run reset restores the quiet policy.

// File: rtl/mabort_pkg.sv
package mabort_pkg;

  localparam int CLS_W = 2;
  localparam int ST_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_HUB_CR     = 2'd0,
    CLS_HUB_POSTED = 2'd1,
    CLS_PCI_RD     = 2'd2,
    CLS_PCI_WR     = 2'd3
  } txn_cls_e;

  typedef enum logic [ST_W-1:0] {
    ST_NORMAL    = 2'd0,
    ST_MST_ABORT = 2'd1,
    ST_TGT_ABORT = 2'd2
  } resp_st_e;

  typedef struct packed {
    logic     valid;
    resp_st_e status;
    logic     force_ones;
    logic     discard;
    logic     relay;
    logic     flush;
    logic     tgt_abort;
    logic     serr;
  } resp_t;

  // Response decision for one abort event.
  function automatic resp_t decide_resp(input txn_cls_e cls,
                                        input logic     as_error,
                                        input logic     serr_en);
    resp_t r;
    r       = '0;
    r.valid = 1'b1;
    unique case (cls)
      CLS_HUB_CR: begin
        r.status     = as_error ? ST_TGT_ABORT : ST_MST_ABORT;
        r.force_ones = 1'b1;
      end
      CLS_HUB_POSTED: begin
        r.discard = 1'b1;
        r.serr    = as_error & serr_en;
      end
      CLS_PCI_RD: begin
        if (as_error) begin
          r.status    = ST_TGT_ABORT;
          r.flush     = 1'b1;
          r.tgt_abort = 1'b1;
        end else begin
          r.relay = 1'b1;
        end
      end
      default: r.valid = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mabort_cfg_regs.sv
module mabort_cfg_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_abort_is_err,
  input  logic cfg_serr_en,
  output logic as_error_q,
  output logic serr_en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_error_q <= 1'b0;
      serr_en_q  <= 1'b0;
    end else if (cfg_we) begin
      as_error_q <= cfg_abort_is_err;
      serr_en_q  <= cfg_serr_en;
    end
  end

endmodule

// File: rtl/mabort_resp_stage.sv
module mabort_resp_stage
  import mabort_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     abort_stb,
  input  txn_cls_e cls,
  input  logic     as_error,
  input  logic     serr_en,
  output resp_t    resp_d,
  output resp_t    resp_q
);

  always_comb begin
    resp_d = '0;
    if (abort_stb) resp_d = decide_resp(cls, as_error, serr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else        resp_q <= resp_d;
  end

endmodule

// File: rtl/mabort_serr_status.sv
module mabort_serr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic sticky_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sticky_q <= 1'b0;
    else if (set_evt) sticky_q <= 1'b1;
    else if (clr_evt) sticky_q <= 1'b0;
  end

endmodule

// File: rtl/mabort_handler.sv
module mabort_handler
  import mabort_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_abort_is_err,
  input  logic            cfg_serr_en,
  input  logic            serr_clr,
  input  logic            abort_stb,
  input  logic [CLS_W-1:0] txn_class,
  output logic            resp_valid,
  output logic [ST_W-1:0] resp_status,
  output logic            force_ones,
  output logic            discard,
  output logic            relay_pkt_data,
  output logic            flush_prefetch,
  output logic            tgt_abort_req,
  output logic            serr_req,
  output logic            serr_sticky
);

  logic  as_error_w;
  logic  serr_en_w;
  logic  serr_set_w;
  resp_t resp_next_w;
  resp_t resp_w;

  mabort_cfg_regs u_cfg (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_we           (cfg_we),
    .cfg_abort_is_err (cfg_abort_is_err),
    .cfg_serr_en      (cfg_serr_en),
    .as_error_q       (as_error_w),
    .serr_en_q        (serr_en_w)
  );

  mabort_resp_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_stb (abort_stb),
    .cls       (txn_cls_e'(txn_class)),
    .as_error  (as_error_w),
    .serr_en   (serr_en_w),
    .resp_d    (resp_next_w),
    .resp_q    (resp_w)
  );

  assign serr_set_w = resp_next_w.serr;

  mabort_serr_status u_serr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (serr_set_w),
    .clr_evt  (serr_clr),
    .sticky_q (serr_sticky)
  );

  assign resp_valid     = resp_w.valid;
  assign resp_status    = resp_w.status;
  assign force_ones     = resp_w.force_ones;
  assign discard        = resp_w.discard;
  assign relay_pkt_data = resp_w.relay;
  assign flush_prefetch = resp_w.flush;
  assign tgt_abort_req  = resp_w.tgt_abort;
  assign serr_req       = resp_w.serr;

endmodule

// File: rtl/mabort_checker.sv
module mabort_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       abort_stb,
  input logic [1:0] txn_class,
  input logic       serr_clr,
  input logic       as_error,
  input logic       serr_en,
  input logic       resp_valid,
  input logic [1:0] resp_status,
  input logic       force_ones,
  input logic       discard,
  input logic       relay_pkt_data,
  input logic       flush_prefetch,
  input logic       tgt_abort_req,
  input logic       serr_req,
  input logic       serr_sticky
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r2_cr_master_abort: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(abort_stb && txn_class == 2'd0 && !as_error)
      |-> resp_valid && resp_status == 2'b01 && force_ones && !tgt_abort_req);

  a_r3_cr_target_abort: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(abort_stb && txn_class == 2'd0 && as_error)
      |-> resp_valid && resp_status == 2'b10 && force_ones);

  a_r4_posted_discard: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(abort_stb && txn_class == 2'd1)
      |-> discard && resp_status == 2'b00 && !force_ones);

  a_r5_serr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    armed && serr_req |-> $past(abort_stb && txn_class == 2'd1 && as_error && serr_en));

  a_r5_serr_records: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> serr_sticky);

  a_r6_read_relay: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(abort_stb && txn_class == 2'd2 && !as_error)
      |-> relay_pkt_data && !flush_prefetch && !tgt_abort_req);

  a_r7_read_terminate: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(abort_stb && txn_class == 2'd2 && as_error)
      |-> tgt_abort_req && flush_prefetch && resp_status == 2'b10);

  a_r8_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(abort_stb && txn_class == 2'd3) |-> !resp_valid && !serr_req);

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(abort_stb)
      |-> !resp_valid && resp_status == 2'b00 && !force_ones && !discard
          && !relay_pkt_data && !flush_prefetch && !tgt_abort_req && !serr_req);

  a_r10_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    serr_sticky && !serr_clr |=> serr_sticky);

endmodule

bind mabort_handler mabort_checker u_mabort_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .abort_stb      (abort_stb),
  .txn_class      (txn_class),
  .serr_clr       (serr_clr),
  .as_error       (as_error_w),
  .serr_en        (serr_en_w),
  .resp_valid     (resp_valid),
  .resp_status    (resp_status),
  .force_ones     (force_ones),
  .discard        (discard),
  .relay_pkt_data (relay_pkt_data),
  .flush_prefetch (flush_prefetch),
  .tgt_abort_req  (tgt_abort_req),
  .serr_req       (serr_req),
  .serr_sticky    (serr_sticky)
);

// File: tb/test_mabort_handler.sv
module test_mabort_handler;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_abort_is_err = 1'b0, cfg_serr_en = 1'b0;
  logic       serr_clr = 1'b0, abort_stb = 1'b0;
  logic [1:0] txn_class = 2'd0;
  logic       resp_valid, force_ones, discard, relay_pkt_data;
  logic       flush_prefetch, tgt_abort_req, serr_req, serr_sticky;
  logic [1:0] resp_status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  mabort_handler i_mabort_handler (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_abort_is_err(cfg_abort_is_err),
    .cfg_serr_en(cfg_serr_en), .serr_clr(serr_clr), .abort_stb(abort_stb),
    .txn_class(txn_class), .resp_valid(resp_valid), .resp_status(resp_status),
    .force_ones(force_ones), .discard(discard), .relay_pkt_data(relay_pkt_data),
    .flush_prefetch(flush_prefetch), .tgt_abort_req(tgt_abort_req),
    .serr_req(serr_req), .serr_sticky(serr_sticky)
  );

  // {policy, enable, class[1:0], valid, status[1:0], ones, discard, relay, flush, ta, serr}
  localparam logic [12:0] VECS [10] = '{
    {1'b0, 1'b1, 2'd0, 9'b1_01_1_0_0_0_0_0},
    {1'b0, 1'b1, 2'd1, 9'b1_00_0_1_0_0_0_0},
    {1'b0, 1'b1, 2'd2, 9'b1_00_0_0_1_0_0_0},
    {1'b0, 1'b1, 2'd3, 9'b0_00_0_0_0_0_0_0},
    {1'b1, 1'b1, 2'd0, 9'b1_10_1_0_0_0_0_0},
    {1'b1, 1'b1, 2'd1, 9'b1_00_0_1_0_0_0_1},
    {1'b1, 1'b1, 2'd2, 9'b1_10_0_0_0_1_1_0},
    {1'b1, 1'b1, 2'd3, 9'b0_00_0_0_0_0_0_0},
    {1'b1, 1'b0, 2'd1, 9'b1_00_0_1_0_0_0_0},
    {1'b0, 1'b0, 2'd1, 9'b1_00_0_1_0_0_0_0}
  };

  function automatic logic [8:0] outs();
    return {resp_valid, resp_status, force_ones, discard, relay_pkt_data,
            flush_prefetch, tgt_abort_req, serr_req};
  endfunction

  function automatic string tag_of(logic m, logic e, logic [1:0] c);
    case (c)
      2'd0:    return m ? "R3" : "R2";
      2'd1:    return (m && e) ? "R5" : "R4";
      2'd2:    return m ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic configure(logic m, logic e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_abort_is_err = m; cfg_serr_en = e; serr_clr = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; serr_clr = 1'b0;
  endtask

  task automatic strobe(logic [1:0] c);
    abort_stb = 1'b1; txn_class = c;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outputs in reset", {outs(), serr_sticky}, 10'd0);
    rst_n = 1'b1;
    @(negedge clk);
    strobe(2'd0);
    check("R1 default policy 0", outs(), 9'b1_01_1_0_0_0_0_0);
    @(negedge clk); abort_stb = 1'b0;
    @(posedge clk); #1;
    check("R9 idle after strobe", outs(), 9'd0);

    // Vector table: every class under both policies
    foreach (VECS[i]) begin
      configure(VECS[i][12], VECS[i][11]);
      strobe(VECS[i][10:9]);
      check(tag_of(VECS[i][12], VECS[i][11], VECS[i][10:9]), outs(), VECS[i][8:0]);
      check("R5 sticky follows request", {8'd0, serr_sticky}, {8'd0, VECS[i][0]});
      @(negedge clk); abort_stb = 1'b0;
      @(posedge clk); #1;
      check("R9 one-cycle response", outs(), 9'd0);
    end

    // R10: set wins over clear, then hold, then clear
    configure(1'b1, 1'b1);
    serr_clr = 1'b1;
    strobe(2'd1);
    check("R10 set wins over clear", {8'd0, serr_sticky}, 9'd1);
    @(negedge clk); abort_stb = 1'b0; serr_clr = 1'b0;
    repeat (3) @(posedge clk); #1;
    check("R10 sticky holds", {serr_req, serr_sticky}, 2'b01);
    @(negedge clk); serr_clr = 1'b1;
    @(posedge clk); #1;
    check("R10 clear strobe", {8'd0, serr_sticky}, 9'd0);
    @(negedge clk); serr_clr = 1'b0;

    // R11: strobe in the same cycle as a configuration write uses the old policy
    cfg_we = 1'b1; cfg_abort_is_err = 1'b0; cfg_serr_en = 1'b0;
    strobe(2'd0);
    check("R11 old policy same cycle", outs(), 9'b1_10_1_0_0_0_0_0);
    @(negedge clk); cfg_we = 1'b0;
    strobe(2'd0);
    check("R11 new policy next cycle", outs(), 9'b1_01_1_0_0_0_0_0);
    @(negedge clk); abort_stb = 1'b0;

    // R1: reset mid-run clears sticky and restores policy 0
    configure(1'b1, 1'b1);
    strobe(2'd1);
    @(negedge clk); abort_stb = 1'b0;
    rst_n = 1'b0; #1;
    check("R1 reset clears sticky", {8'd0, serr_sticky}, 9'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    strobe(2'd1);
    check("R1 enable and policy cleared by reset", outs(), 9'b1_00_0_1_0_0_0_0);
    @(negedge clk); abort_stb = 1'b0;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule